// File: doc/BRIEF.md
# Slow-Idle Clock Enable Controller

This block sits between a processor core and its clock tree and manages the core's low-power idle state without touching the clock itself. It turns the clock into enable strobes: one for the core and one each for the serial-port clock, the clock output and the timer tick. When the core executes an idle instruction it raises a one-cycle request. The request either halts the core outright (standard idle) or keeps it running at a reduced rate of 1/16, 1/32, 1/64 or 1/128 (divided idle). In divided idle the peripheral enables slow down by the same ratio.

The block watches the interrupt request lines together with their per-line unmask bits. In standard idle an unmasked interrupt brings the core back on the next cycle. In divided idle the wake is held until the next reduced-rate enable, so the wake latency grows with the divisor but never exceeds it. Once full-rate operation is back, the core receives a one-cycle resume strobe, services the interrupt and continues after the idle instruction. DMA and autobuffer cycle-steal requests are granted in every state, idle or not.

Top module: `slow_idle_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `idle_active` and `resume` are 0, `core_ce` is 1 and all three `periph_ce` bits are 1.
- R2: An `idle_req` sampled in a running cycle makes `idle_active` 1 from the next cycle on. `idle_div`=0 selects standard idle. `idle_div`=1 selects divided idle with divisor n given by `idle_sel` (00=16, 01=32, 10=64, 11=128), and that divisor is captured at entry.
- R3: In standard idle, `core_ce` stays 0 for the whole stay and every `periph_ce` bit stays 1.
- R4: In divided idle, `core_ce` is 1 in exactly one cycle out of every n, starting with the n-th cycle in which `idle_active` is 1.
- R5: The bits of `periph_ce` (bit 0 serial clock, bit 1 clock output, bit 2 timer tick) each follow the `core_ce` pattern while divided idle is active, and are 1 in every other state.
- R6: An interrupt wakes the block only if both its `irq_req` bit and the matching `irq_unmask` bit are 1. Masked requests leave the block idle indefinitely.
- R7: In standard idle, an unmasked interrupt in cycle c gives `idle_active`=0 and `resume`=1 in cycle c+1.
- R8: In divided idle, an unmasked interrupt is remembered even if it lasts one cycle. Full rate returns in the cycle after the next `core_ce` strobe, counting a strobe in the cycle of the interrupt itself. An interrupt seen w cycles after entry (w<n) therefore ends idle exactly n-w cycles later, never more than n.
- R9: `resume` is a single-cycle pulse in the first full-rate cycle after idle, and `core_ce` is 1 in that cycle and in every running cycle.
- R10: `steal_gnt` equals `steal_req` in the same cycle in every state.
- R11: An `idle_req` that arrives while already idle is ignored: it leaves the mode, the captured divisor and the enable phase unchanged. Each entry into divided idle restarts the rate divider from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_req | input | 1 | One-cycle idle request from the core |
| idle_div | input | 1 | 1 selects divided idle, 0 standard idle |
| idle_sel | input | 2 | Divisor code: 00=16, 01=32, 10=64, 11=128 |
| irq_req | input | NIRQ (8) | Interrupt request lines |
| irq_unmask | input | NIRQ (8) | Per-line unmask bits, 1 = enabled |
| steal_req | input | NSTEAL (3) | DMA / autobuffer cycle-steal requests |
| core_ce | output | 1 | Core clock enable |
| periph_ce | output | 3 | Enables: bit 0 serial clock, bit 1 clock output, bit 2 timer |
| steal_gnt | output | NSTEAL (3) | Cycle-steal grants |
| idle_active | output | 1 | 1 while in either idle state |
| resume | output | 1 | One-cycle strobe when full rate is restored |

## Verification
Each divisor code is entered with an interrupt arriving at the first, middle and last phase of the reduced-rate period. This separates a wake aligned to the strobe from one that is premature or late by a period, and it exposes divisor codes that have been swapped. One-cycle interrupt pulses separate a remembered wake from one that needs a held line. Masked requests, repeated idle requests and re-entry are tried in both idle modes, and these show whether the mask, the ignore rule and the divider restart are kept. A long random stretch with sparse requests and steal traffic is compared cycle by cycle against a behavioural model.

// File: rtl/sic_pkg.sv
package sic_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_SLOW = 2'd2
  } sic_state_e;

  // Divisor for a selection code: 2^(base_log2 + code)
  function automatic int unsigned div_ratio(input int unsigned code,
                                            input int unsigned base_log2);
    return 32'd1 << (base_log2 + code);
  endfunction

  // Wake latency for an interrupt seen at divider phase `phase`
  function automatic int unsigned wake_latency(input int unsigned ratio,
                                               input int unsigned phase);
    return ratio - phase;
  endfunction

endpackage

// File: rtl/sic_divider.sv
module sic_divider #(
  parameter int BASE_LOG2 = 4,
  parameter int SEL_W     = 2,
  localparam int CNT_W    = BASE_LOG2 + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick,
  output logic [CNT_W-1:0] phase
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;

  assign term  = CNT_W'(sic_pkg::div_ratio(32'(sel), 32'(BASE_LOG2)) - 32'd1);
  assign tick  = run && (cnt_q == term);
  assign phase = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R4
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= term));

  // R11
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt_q == '0));

endmodule

// File: rtl/sic_wake.sv
module sic_wake #(
  parameter int NIRQ = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_unmask,
  input  logic            arm,
  output logic            hit,
  output logic            pend
);

  logic pend_q;

  assign hit  = |(irq_req & irq_unmask);
  assign pend = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    pend_q <= 1'b0;
    else if (!arm) pend_q <= 1'b0;
    else           pend_q <= pend_q | hit;
  end

  // R8
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && pend_q) |=> (pend_q || !arm));

endmodule

// File: rtl/sic_fsm.sv
module sic_fsm #(
  parameter int SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 idle_req,
  input  logic                 idle_div,
  input  logic [SEL_W-1:0]     idle_sel,
  input  logic                 hit,
  input  logic                 pend,
  input  logic                 tick,
  output sic_pkg::sic_state_e  state,
  output logic [SEL_W-1:0]     sel_q,
  output logic                 resume
);
  import sic_pkg::*;

  sic_state_e       st_q, st_d;
  logic [SEL_W-1:0] sel_d;
  logic             wake_go;

  always_comb begin
    st_d    = st_q;
    sel_d   = sel_q;
    wake_go = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (idle_req) begin
          st_d  = idle_div ? ST_SLOW : ST_HALT;
          sel_d = idle_sel;
        end
      end
      ST_HALT: begin
        if (hit) begin
          st_d    = ST_RUN;
          wake_go = 1'b1;
        end
      end
      ST_SLOW: begin
        if (tick && (hit || pend)) begin
          st_d    = ST_RUN;
          wake_go = 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      sel_q  <= '0;
      resume <= 1'b0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      resume <= wake_go;
    end
  end

  assign state = st_q;

  // R7
  halt_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HALT && hit) |=> (st_q == ST_RUN && resume));

  // R6
  masked_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HALT && !hit) |=> (st_q == ST_HALT));

  // R9
  resume_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume);

  // R11
  ignore_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_RUN && idle_req) |=> $stable(sel_q));

endmodule

// File: rtl/slow_idle_ctrl.sv
module slow_idle_ctrl #(
  parameter int NIRQ      = 8,
  parameter int NSTEAL    = 3,
  parameter int BASE_LOG2 = 4,
  parameter int SEL_W     = 2,
  parameter int NPERIPH   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_req,
  input  logic              idle_div,
  input  logic [SEL_W-1:0]  idle_sel,
  input  logic [NIRQ-1:0]   irq_req,
  input  logic [NIRQ-1:0]   irq_unmask,
  input  logic [NSTEAL-1:0] steal_req,
  output logic              core_ce,
  output logic [NPERIPH-1:0] periph_ce,
  output logic [NSTEAL-1:0] steal_gnt,
  output logic              idle_active,
  output logic              resume
);
  import sic_pkg::*;

  localparam int CNT_W = BASE_LOG2 + (1 << SEL_W) - 1;

  sic_state_e       state_w;
  logic [SEL_W-1:0] sel_w;
  logic             tick_w;
  logic             hit_w;
  logic             pend_w;
  logic             slow_w;
  logic [CNT_W-1:0] phase_w;

  assign slow_w = (state_w == ST_SLOW);

  sic_fsm #(.SEL_W(SEL_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .idle_req (idle_req),
    .idle_div (idle_div),
    .idle_sel (idle_sel),
    .hit      (hit_w),
    .pend     (pend_w),
    .tick     (tick_w),
    .state    (state_w),
    .sel_q    (sel_w),
    .resume   (resume)
  );

  sic_divider #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (slow_w),
    .sel   (sel_w),
    .tick  (tick_w),
    .phase (phase_w)
  );

  sic_wake #(.NIRQ(NIRQ)) u_wake (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .irq_unmask (irq_unmask),
    .arm        (slow_w),
    .hit        (hit_w),
    .pend       (pend_w)
  );

  always_comb begin
    unique case (state_w)
      ST_HALT: core_ce = 1'b0;
      ST_SLOW: core_ce = tick_w;
      default: core_ce = 1'b1;
    endcase
  end

  for (genvar g = 0; g < NPERIPH; g++) begin : g_periph
    assign periph_ce[g] = slow_w ? tick_w : 1'b1;
  end

  assign steal_gnt   = steal_req;
  assign idle_active = (state_w != ST_RUN);

  // Wake latency watch: cycles since an unmasked interrupt was seen in divided idle
  logic [CNT_W:0] lat_q;
  logic [CNT_W:0] ratio_w;

  assign ratio_w = (CNT_W+1)'(div_ratio(32'(sel_w), 32'(BASE_LOG2)));

  always_ff @(posedge clk) begin
    if (!rst_n || !slow_w)          lat_q <= '0;
    else if ((pend_w || hit_w) && lat_q != ratio_w) lat_q <= lat_q + 1'b1;
  end

  // R8
  wake_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slow_w |-> (lat_q < ratio_w));

  // R5
  periph_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slow_w |-> (periph_ce == {NPERIPH{core_ce}}));

  // R9
  resume_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> (core_ce && !idle_active && $past(idle_active)));

  // R3
  halt_core_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_active && !slow_w) |-> (!core_ce && (&periph_ce)));

endmodule

// File: tb/slow_idle_ctrl_test.sv
module slow_idle_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NIRQ   = 8;
  localparam int NSTEAL = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic idle_req, idle_div;
  logic [1:0] idle_sel;
  logic [NIRQ-1:0] irq_req, irq_unmask;
  logic [NSTEAL-1:0] steal_req;
  logic core_ce;
  logic [2:0] periph_ce;
  logic [NSTEAL-1:0] steal_gnt;
  logic idle_active, resume;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // behavioural reference state
  int m_mode;   // 0 running, 1 halted idle, 2 divided idle
  int m_cnt;
  int m_n;
  bit m_pend;
  bit m_resume;

  always #(CLK_PERIOD/2) clk = ~clk;

  slow_idle_ctrl uut (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .idle_div(idle_div),
    .idle_sel(idle_sel), .irq_req(irq_req), .irq_unmask(irq_unmask),
    .steal_req(steal_req), .core_ce(core_ce), .periph_ce(periph_ce),
    .steal_gnt(steal_gnt), .idle_active(idle_active), .resume(resume)
  );

  task automatic chk(input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare outputs against the model, advance the model, move to next negedge
  task automatic cyc();
    bit tick, hit;
    int e_core;
    #1;
    tick = (m_mode == 2) && (m_cnt == m_n - 1);
    hit  = |(irq_req & irq_unmask);
    e_core = (m_mode == 0) ? 1 : (m_mode == 1) ? 0 : int'(tick);
    chk(m_mode == 1 ? "R3" : (m_mode == 2 ? "R4" : "R9"), "core_ce", int'(core_ce), e_core);
    chk("R5", "periph_ce", int'(periph_ce), (m_mode == 2) ? (tick ? 7 : 0) : 7);
    chk("R2", "idle_active", int'(idle_active), int'(m_mode != 0));
    chk("R9", "resume", int'(resume), int'(m_resume));
    chk("R10", "steal_gnt", int'(steal_gnt), int'(steal_req));
    m_resume = 0;
    case (m_mode)
      0: if (idle_req) begin
           m_mode = idle_div ? 2 : 1;
           m_n = 16 * (1 << idle_sel);
           m_cnt = 0;
           m_pend = 0;
         end
      1: if (hit) begin
           m_mode = 0;
           m_resume = 1;
         end
      default: begin
        if (tick && (m_pend || hit)) begin
          m_mode = 0; m_resume = 1; m_cnt = 0; m_pend = 0;
        end else begin
          m_pend = m_pend | hit;
          m_cnt = tick ? 0 : m_cnt + 1;
        end
      end
    endcase
    @(negedge clk);
  endtask

  task automatic run_cycles(input int k);
    for (int i = 0; i < k; i++) cyc();
  endtask

  task automatic enter_idle(input bit dv, input logic [1:0] sel);
    idle_req = 1; idle_div = dv; idle_sel = sel;
    cyc();
    idle_req = 0;
  endtask

  // Divided idle with an interrupt pulse w cycles after entry
  task automatic div_wake(input logic [1:0] sel, input int w);
    int n, lat;
    n = 16 << sel;
    enter_idle(1'b1, sel);
    run_cycles(w);
    irq_req = 8'h10; irq_unmask = 8'h10;
    cyc();
    irq_req = 0;
    lat = 1;
    while (!resume && lat < 300) begin
      cyc();
      lat++;
    end
    chk("R8", $sformatf("wake latency n=%0d w=%0d", n, w), lat, n - w);
    chk("R8", "latency bound", int'(lat <= n), 1);
    irq_unmask = 0;
    run_cycles(2);
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 100000 && !done; wd++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle_req = 0; idle_div = 0; idle_sel = 0;
    irq_req = 0; irq_unmask = 0; steal_req = 0;
    m_mode = 0; m_cnt = 0; m_n = 16; m_pend = 0; m_resume = 0;
    @(negedge clk); @(negedge clk);
    // R1 reset values
    chk("R1", "core_ce in reset", int'(core_ce), 1);
    chk("R1", "periph_ce in reset", int'(periph_ce), 7);
    chk("R1", "idle_active in reset", int'(idle_active), 0);
    chk("R1", "resume in reset", int'(resume), 0);
    rst_n = 1;
    @(negedge clk);
    // R10 grants while running
    for (int i = 0; i < 6; i++) begin
      steal_req = NSTEAL'(i);
      cyc();
    end

    // Standard idle, masked then unmasked interrupt
    enter_idle(1'b0, 2'b11);
    steal_req = 3'b101;
    irq_req = 8'hFF; irq_unmask = 8'h00;
    run_cycles(8);
    chk("R6", "still idle with masked irq", int'(idle_active), 1);
    irq_req = 8'h0F; irq_unmask = 8'hF0;
    run_cycles(4);
    chk("R6", "disjoint mask keeps idle", int'(idle_active), 1);
    idle_req = 1; idle_div = 1; idle_sel = 2'b00;
    cyc();
    idle_req = 0;
    chk("R11", "request while halted ignored", int'(core_ce), 0);
    irq_req = 8'h01; irq_unmask = 8'h01;
    cyc();
    chk("R7", "one-cycle wake idle_active", int'(idle_active), 0);
    chk("R7", "one-cycle wake resume", int'(resume), 1);
    irq_req = 0; irq_unmask = 0;
    cyc();
    chk("R9", "resume single cycle", int'(resume), 0);

    // Divided idle with masked interrupts: steady strobes
    enter_idle(1'b1, 2'b00);
    irq_req = 8'hAA; irq_unmask = 8'h55;
    run_cycles(40);
    chk("R6", "divided idle masked stays", int'(idle_active), 1);
    // R11 repeated request mid-idle keeps the phase
    idle_req = 1; idle_div = 1; idle_sel = 2'b11;
    cyc();
    idle_req = 0;
    run_cycles(40);
    irq_req = 0; irq_unmask = 0;
    // wake to leave
    irq_req = 8'h02; irq_unmask = 8'h02;
    run_cycles(20);
    irq_req = 0; irq_unmask = 0;
    run_cycles(3);
    chk("R9", "back to full rate", int'(core_ce), 1);

    // R8 latency across codes and phases
    for (int s = 0; s < 4; s++) begin
      div_wake(2'(s), 0);
      div_wake(2'(s), (16 << s) / 2);
      div_wake(2'(s), (16 << s) - 1);
    end

    // R11 immediate re-entry restarts divider
    enter_idle(1'b1, 2'b01);
    run_cycles(7);
    irq_req = 8'h80; irq_unmask = 8'h80;
    run_cycles(26);
    irq_req = 0; irq_unmask = 0;
    enter_idle(1'b1, 2'b01);
    run_cycles(70);

    // Random stretch
    for (int i = 0; i < 4000; i++) begin
      idle_req   = ($urandom_range(0, 39) == 0);
      idle_div   = $urandom_range(0, 1) == 1;
      idle_sel   = 2'($urandom_range(0, 3));
      irq_req    = ($urandom_range(0, 49) == 0) ? NIRQ'($urandom) : '0;
      irq_unmask = NIRQ'($urandom);
      steal_req  = NSTEAL'($urandom);
      cyc();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule